// File: doc/BRIEF.md
# Predictive synchronous rectifier gate sequencer

This block drives the two rectifier switches on the secondary side of a forward converter. It produces two gate-enable levels from a digitized synchronizing clock. The forward gate may conduct while the filtered clock is high, and the freewheeling gate while it is low. Each phase is measured in system-clock ticks. The length measured in one phase becomes the prediction for the same phase in the next period. Each gate then drops a fixed number of ticks before the predicted end of its phase, so it is already off when the opposite switch turns on.

Several inputs gate the two outputs. A level-sensitive inhibit cuts the freewheeling gate short after a minimum conduction time, which permits discontinuous conduction. A duty-cycle monitor with hysteresis shuts both gates when the high phase becomes too short a fraction of the period. A bypass input disables that monitor. A supply-good input blocks both gates and discards every measurement. Clock pulses narrower than a minimum width are filtered out and count as no edge.

Top module: `sr_gate_seq`

## Requirements
- R1: After reset, and after supply_ok returns, both gates stay low until one complete high phase and one complete low phase have been measured. Each of these phases must start at a filtered clock edge that occurs while supply_ok is high.
- R2: gate_fwd is high only while the filtered clock is high. During a high phase it is on for the first H-4 ticks and off for the last 4 ticks of the predicted phase, where H is the length of the previous high phase.
- R3: gate_fw is high only while the filtered clock is low. It is on for the first L-A ticks, where L is the length of the previous low phase. A is 15, 30 and 45 ticks for ant_sel values 0, 1 and 2, and 45 for value 3.
- R4: Both predictions are refreshed every period. A new phase length takes effect in the next phase of the same kind.
- R5: A gate stays low for an entire phase when its predicted length is not larger than its anticipation.
- R6: The filtered clock takes a new level of sync_in only after that level has been sampled for 40 consecutive ticks. Shorter pulses change nothing.
- R7: While inhibit is high, gate_fw is limited to the first 50 ticks of a low phase. inhibit acts as a level, so gate_fw returns as soon as inhibit falls.
- R8: The duty check runs at each filtered rising edge, using the last high length h and the low length l that just ended. The block shuts down when 100*h < 13*(h+l) and recovers when 100*h >= 14*(h+l). Between the two limits the current state is kept. While shut down, both gates are low and measurement continues.
- R9: While duty_bypass is high at that rising-edge check, the block is not shut down, and any shutdown in place is cleared.
- R10: While supply_ok is low, both gates are low.
- R11: gate_fwd and gate_fw are never high in the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Synchronized converter clock level |
| supply_ok | input | 1 | Supply-good level; low blocks the gates |
| inhibit | input | 1 | Limits freewheeling conduction while high |
| ant_sel | input | 2 | Freewheeling anticipation select |
| duty_bypass | input | 1 | Disables the low-duty shutdown |
| gate_fwd | output | 1 | Forward rectifier gate enable |
| gate_fw | output | 1 | Freewheeling rectifier gate enable |

## Verification
The bench targets the following corner cases. A sudden change of period: a design that used the current phase instead of the previous one would drop its gate at the wrong tick. A narrow glitch inside either phase: a design that accepted it would restart the measurement and collapse the prediction. A duty cycle that sits between the two limits: a design without hysteresis would wake the gates there. A low phase shorter than the anticipation: a design that wrapped the subtraction would leave the freewheeling gate on for the whole phase. After supply loss, the bench checks that no gate fires in the first period; a design that kept stale measurements would fire one.

// File: rtl/sr_gate_seq.sv
module sr_gate_seq #(
  parameter int CNT_W     = 16,
  parameter int FILT      = 40,
  parameter int ANT_FWD   = 4,
  parameter int ANT_FW_S  = 15,
  parameter int ANT_FW_M  = 30,
  parameter int ANT_FW_L  = 45,
  parameter int MIN_ON_FW = 50,
  parameter int SHUT_PCT  = 13,
  parameter int WAKE_PCT  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       supply_ok,
  input  logic       inhibit,
  input  logic [1:0] ant_sel,
  input  logic       duty_bypass,
  output logic       gate_fwd,
  output logic       gate_fw
);
  localparam int FLT_W = $clog2(FILT) + 1;
  localparam logic [CNT_W-1:0] PH_TOP = {CNT_W{1'b1}} - 1'b1;

  logic             lvl, seen, hi_ok, lo_ok, shut;
  logic [FLT_W-1:0] flt_cnt;
  logic [CNT_W-1:0] ph_cnt, hi_meas, lo_meas, len_now;
  logic [31:0]      age, ant_fw, per_len, hi_x100;
  logic             flip, armed, duty_low, duty_ok;

  assign flip     = (sync_in != lvl) && (flt_cnt == FLT_W'(FILT - 1));
  assign len_now  = ph_cnt + 1'b1;
  assign age      = 32'(ph_cnt);
  assign armed    = hi_ok && lo_ok && !shut && supply_ok;
  assign per_len  = 32'(hi_meas) + 32'(len_now);
  assign hi_x100  = 32'(hi_meas) * 32'd100;
  assign duty_low = hi_x100 < per_len * 32'(SHUT_PCT);
  assign duty_ok  = hi_x100 >= per_len * 32'(WAKE_PCT);

  always_comb begin
    case (ant_sel)
      2'd0:    ant_fw = 32'(ANT_FW_S);
      2'd1:    ant_fw = 32'(ANT_FW_M);
      default: ant_fw = 32'(ANT_FW_L);
    endcase
  end

  assign gate_fwd = armed && lvl && (age + 32'(ANT_FWD) < 32'(hi_meas));
  assign gate_fw  = armed && !lvl && (age + ant_fw < 32'(lo_meas)) &&
                    (!inhibit || age < 32'(MIN_ON_FW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= 1'b0;
      flt_cnt <= '0;
      ph_cnt  <= '0;
      hi_meas <= '0;
      lo_meas <= '0;
      seen    <= 1'b0;
      hi_ok   <= 1'b0;
      lo_ok   <= 1'b0;
      shut    <= 1'b0;
    end else begin
      if (sync_in == lvl || flip) flt_cnt <= '0;
      else                        flt_cnt <= flt_cnt + 1'b1;

      if (flip) begin
        lvl    <= ~lvl;
        ph_cnt <= '0;
      end else if (ph_cnt != PH_TOP) begin
        ph_cnt <= ph_cnt + 1'b1;
      end

      if (!supply_ok) begin
        seen  <= 1'b0;
        hi_ok <= 1'b0;
        lo_ok <= 1'b0;
        shut  <= 1'b0;
      end else if (flip) begin
        seen <= 1'b1;
        if (lvl) begin
          hi_meas <= len_now;
          if (seen) hi_ok <= 1'b1;
        end else begin
          lo_meas <= len_now;
          if (seen) lo_ok <= 1'b1;
          if (hi_ok) begin
            if (duty_bypass)   shut <= 1'b0;
            else if (duty_low) shut <= 1'b1;
            else if (duty_ok)  shut <= 1'b0;
          end
        end
      end
    end
  end

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_fwd && gate_fw));

  p_supply_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (!gate_fwd && !gate_fw));

  p_unmeasured_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_ok && lo_ok) |-> (!gate_fwd && !gate_fw));

  p_filter_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> ($past(flt_cnt) == FLT_W'(FILT - 1) && $past(sync_in) == lvl));

  p_shut_at_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shut && !$past(shut)) |-> ($past(flip) && !$past(lvl) && !$past(duty_bypass)));

  p_shut_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shut |-> (!gate_fwd && !gate_fw));
endmodule

// File: tb/sr_gate_seq_test.sv
module sr_gate_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0, supply_ok = 1'b1, inhibit = 1'b0, duty_bypass = 1'b0;
  logic [1:0] ant_sel = 2'd0;
  logic gate_fwd, gate_fw;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sr_gate_seq uut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .supply_ok(supply_ok),
    .inhibit(inhibit), .ant_sel(ant_sel), .duty_bypass(duty_bypass),
    .gate_fwd(gate_fwd), .gate_fw(gate_fw));

  int m_lvl = 0, m_run = 0, m_age = 0, m_hi = 0, m_lo = 0;
  int m_seen = 0, m_hok = 0, m_lok = 0, m_shut = 0;
  int cur_f = 0, cur_w = 0, last_f = 0, last_w = 0, tot_f = 0, tot_w = 0;

  function automatic int ant_of(input logic [1:0] s);
    if (s == 2'd0) return 15;
    if (s == 2'd1) return 30;
    return 45;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int flip, len, o_lvl, o_seen, o_hok;
    flip = (int'(sync_in) != m_lvl) && (m_run == 39);
    if (int'(sync_in) == m_lvl || flip) m_run = 0; else m_run++;
    len = m_age + 1;
    o_lvl = m_lvl; o_seen = m_seen; o_hok = m_hok;
    if (!supply_ok) begin
      m_seen = 0; m_hok = 0; m_lok = 0; m_shut = 0;
    end else if (flip) begin
      m_seen = 1;
      if (o_lvl) begin
        m_hi = len;
        if (o_seen) m_hok = 1;
      end else begin
        if (o_seen) m_lok = 1;
        if (o_hok) begin
          if (duty_bypass) m_shut = 0;
          else if (100 * m_hi < 13 * (m_hi + len)) m_shut = 1;
          else if (100 * m_hi >= 14 * (m_hi + len)) m_shut = 0;
        end
        m_lo = len;
      end
    end
    if (flip) begin m_lvl = 1 - m_lvl; m_age = 0; end else m_age++;
  endtask

  task automatic cyc(input logic raw);
    int on, ef, ew;
    @(negedge clk);
    on = m_hok && m_lok && !m_shut && supply_ok;
    ef = on && m_lvl && (m_age + 4 < m_hi);
    ew = on && !m_lvl && (m_age + ant_of(ant_sel) < m_lo) && (!inhibit || m_age < 50);
    check("R2 gate_fwd vs model", int'(gate_fwd), ef);
    check("R3/R7 gate_fw vs model", int'(gate_fw), ew);
    check("R11 exclusive", int'(gate_fwd && gate_fw), 0);
    if (gate_fwd) begin cur_f++; tot_f++; end else if (cur_f > 0) begin last_f = cur_f; cur_f = 0; end
    if (gate_fw) begin cur_w++; tot_w++; end else if (cur_w > 0) begin last_w = cur_w; cur_w = 0; end
    sync_in = raw;
    model_step();
  endtask

  task automatic period(input int hi, input int lo, input int n);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < hi; i++) cyc(1'b1);
      for (int i = 0; i < lo; i++) cyc(1'b0);
    end
  endtask

  task automatic clr();
    tot_f = 0; tot_w = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset gate_fwd", int'(gate_fwd), 0);
    check("R1 reset gate_fw", int'(gate_fw), 0);
    rst_n = 1'b1;

    // R1: nothing during the first period
    period(100, 100, 1);
    check("R1 no gate in first period fwd", tot_f, 0);
    check("R1 no gate in first period fw", tot_w, 0);
    period(100, 100, 3);
    check("R2 forward run H-4", last_f, 96);
    check("R3 freewheel run sel0", last_w, 85);

    // R4: period change applies one period later
    period(150, 50, 1);
    check("R4 forward uses previous high", last_f, 96);
    period(150, 50, 1);
    check("R4 forward uses new high", last_f, 146);
    period(100, 100, 2);

    // R3: anticipation selects
    ant_sel = 2'd1; period(100, 100, 2);
    check("R3 freewheel run sel1", last_w, 70);
    ant_sel = 2'd2; period(100, 100, 2);
    check("R3 freewheel run sel2", last_w, 55);
    ant_sel = 2'd3; period(100, 100, 2);
    check("R3 freewheel run sel3", last_w, 55);

    // R5: low phase not longer than anticipation
    period(156, 44, 2); clr();
    period(156, 44, 2);
    check("R5 freewheel suppressed", tot_w, 0);
    check("R5 forward still runs", last_f, 152);
    ant_sel = 2'd0;
    period(100, 100, 2);

    // R6: glitches in both phases
    for (int i = 0; i < 45; i++) cyc(1'b1);
    for (int i = 0; i < 10; i++) cyc(1'b0);
    for (int i = 0; i < 45; i++) cyc(1'b1);
    for (int i = 0; i < 30; i++) cyc(1'b0);
    for (int i = 0; i < 39; i++) cyc(1'b1);
    for (int i = 0; i < 31; i++) cyc(1'b0);
    period(100, 100, 1);
    check("R6 glitch ignored forward", last_f, 96);
    check("R6 glitch ignored freewheel", last_w, 85);

    // R7: inhibit
    inhibit = 1'b1; period(100, 200, 2);
    check("R7 inhibit min conduction", last_w, 50);
    inhibit = 1'b0; period(100, 200, 2);
    check("R7 inhibit released", last_w, 185);

    // R8: duty shutdown with hysteresis
    period(50, 400, 2); clr();
    period(64, 396, 2);
    check("R8 shut fwd", tot_f, 0);
    check("R8 hysteresis holds fw", tot_w, 0);
    period(70, 390, 1); clr();
    period(70, 390, 2);
    check("R8 wake runs forward", last_f, 66);
    check("R8 wake runs freewheel", last_w, 375);

    // R9: bypass
    duty_bypass = 1'b1; period(45, 455, 3);
    check("R9 bypass forward run", last_f, 41);
    check("R9 bypass freewheel run", last_w, 440);
    duty_bypass = 1'b0; period(100, 100, 2);

    // R10 / R1: supply loss
    supply_ok = 1'b0; clr();
    period(100, 100, 2);
    check("R10 supply low fwd", tot_f, 0);
    check("R10 supply low fw", tot_w, 0);
    supply_ok = 1'b1; clr();
    period(100, 100, 1);
    check("R1 remeasure after supply fwd", tot_f, 0);
    check("R1 remeasure after supply fw", tot_w, 0);
    period(100, 100, 2);
    check("R1 resumes after supply", last_f, 96);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule